// File: doc/BRIEF.md
# Two-Source Interrupt Flag Controller

This block collects two interrupt sources for a serial port, a transmit source and a receive source, into one interrupt line. Each source has a sticky flag. The flag is set when the source's hardware condition is present, or when software forces it. Software drops the flag by writing a one to the matching clear bit. A per-source enable masks the flags before they reach the status readback and the interrupt output.

The forced set exists for polling. A receive routine that finds bytes waiting below the hardware threshold can raise the receive flag itself, so that the normal interrupt service path runs and drains them. Writing uses a single port with an address and byte data. Reading is combinational on a separate read address.

Top module: `intflag_top`

## Requirements
- R1: Register offsets are fixed: 0 is flag clear, 1 is flag set, 2 is enable and 3 is masked status. In every register bit 0 belongs to transmit and bit 1 to receive. Data bits 7:2 are ignored on write and read as zero.
- R2: Writing offset 1 sets each flag whose data bit is one, even when no hardware condition is present. Zero bits leave their flags unchanged.
- R3: Writing offset 0 clears each flag whose data bit is one. Zero bits leave their flags unchanged.
- R4: A hardware condition (hwCond bit 0 = transmit, bit 1 = receive) that is high at a clock edge sets its flag at that edge. The flag stays set after the condition goes low, until software clears it.
- R5: A clear written while the condition is still high drops the flag for exactly one cycle, and the flag is set again at the next edge.
- R6: Writing offset 2 loads both enable bits at once, and reading offset 2 returns them.
- R7: Reading offset 3 returns the flags ANDed with the enables. Reading offset 0 or 1 returns the flags without the mask.
- R8: irq is high exactly when at least one bit of the masked status is high.
- R9: After reset all flags and enables are zero, every readback is zero and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register write offset |
| wrData | input | 8 | Register write data |
| rdAddr | input | 2 | Register read offset |
| rdData | output | 8 | Read data (combinational) |
| hwCond | input | 2 | Hardware set conditions: bit 0 transmit, bit 1 receive |
| irq | output | 1 | Interrupt output |

## Verification
The bench sweeps every combination of forced flags against every enable pattern, and then every clear mask against every flag pattern. A wrong mask term would show as a status or irq value that disagrees with flags AND enables. A clear or set that disturbs a neighbouring bit would show as a wrong unmasked readback. Separate cases check that the receive flag stays set after its condition falls. They also check that a clear issued during a live condition gives exactly one low cycle before the flag returns; a design that lets the hardware win in the clear cycle would never show the low cycle. High-order write bits are driven to ones to catch decoding that is too wide.

// File: rtl/intflag_pkg.sv
package intflag_pkg;
  localparam int OFS_CLR = 0;
  localparam int OFS_SET = 1;
  localparam int OFS_EN  = 2;
  localparam int OFS_STS = 3;

  typedef struct packed {
    logic clrStb;
    logic setStb;
    logic enStb;
  } regStrobe_t;
endpackage

// File: rtl/intflag_ctrl.sv
module intflag_ctrl
  import intflag_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output regStrobe_t        strobe
);
  always_comb begin
    strobe        = '0;
    strobe.clrStb = wrEn && (wrAddr == ADDR_W'(OFS_CLR));
    strobe.setStb = wrEn && (wrAddr == ADDR_W'(OFS_SET));
    strobe.enStb  = wrEn && (wrAddr == ADDR_W'(OFS_EN));
  end
endmodule

// File: rtl/intflag_dp.sv
module intflag_dp
  import intflag_pkg::*;
#(
  parameter int NUM_SRC = 2,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         strobe,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_SRC-1:0] hwCond,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [DATA_W-1:0]  rdData,
  output logic [NUM_SRC-1:0] flagQ,
  output logic [NUM_SRC-1:0] enQ,
  output logic               irq
);
  logic [NUM_SRC-1:0] maskedSts;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    // Forced set beats clear; clear beats the hardware condition this cycle.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                             flagQ[i] <= 1'b0;
      else if (strobe.setStb && wrData[i])   flagQ[i] <= 1'b1;
      else if (strobe.clrStb && wrData[i])   flagQ[i] <= 1'b0;
      else if (hwCond[i])                    flagQ[i] <= 1'b1;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             enQ[i] <= 1'b0;
      else if (strobe.enStb) enQ[i] <= wrData[i];
    end

    assign maskedSts[i] = flagQ[i] & enQ[i];
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADDR_W'(OFS_CLR), ADDR_W'(OFS_SET): rdData = DATA_W'(flagQ);
      ADDR_W'(OFS_EN):                    rdData = DATA_W'(enQ);
      ADDR_W'(OFS_STS):                   rdData = DATA_W'(maskedSts);
      default:                            rdData = '0;
    endcase
  end

  assign irq = |maskedSts;
endmodule

// File: rtl/intflag_top.sv
module intflag_top
  import intflag_pkg::*;
#(
  parameter int NUM_SRC = 2,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [DATA_W-1:0]  rdData,
  input  logic [NUM_SRC-1:0] hwCond,
  output logic               irq
);
  regStrobe_t         strobe;
  logic [NUM_SRC-1:0] flagQ;
  logic [NUM_SRC-1:0] enQ;

  intflag_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .strobe (strobe)
  );

  intflag_dp #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrData (wrData),
    .hwCond (hwCond),
    .rdAddr (rdAddr),
    .rdData (rdData),
    .flagQ  (flagQ),
    .enQ    (enQ),
    .irq    (irq)
  );
endmodule

// File: rtl/intflag_chk.sv
module intflag_chk #(
  parameter int NUM_SRC = 2,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  wrAddr,
  input logic [DATA_W-1:0]  wrData,
  input logic [ADDR_W-1:0]  rdAddr,
  input logic [DATA_W-1:0]  rdData,
  input logic [NUM_SRC-1:0] hwCond,
  input logic [NUM_SRC-1:0] flagQ,
  input logic [NUM_SRC-1:0] enQ,
  input logic               irq
);
  logic isClr, isSet, isEn;
  assign isClr = wrEn && (wrAddr == ADDR_W'(0));
  assign isSet = wrEn && (wrAddr == ADDR_W'(1));
  assign isEn  = wrEn && (wrAddr == ADDR_W'(2));

  assert_set_forces_R2: assert property (@(posedge clk) disable iff (!rstN)
    isSet |=> ((flagQ & $past(wrData[NUM_SRC-1:0])) == $past(wrData[NUM_SRC-1:0])));

  assert_clear_drops_R3: assert property (@(posedge clk) disable iff (!rstN)
    isClr |=> ((flagQ & $past(wrData[NUM_SRC-1:0])) == '0));

  assert_flags_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    !isClr |=> ((flagQ & $past(flagQ)) == $past(flagQ)));

  assert_hw_sets_rx_R4: assert property (@(posedge clk) disable iff (!rstN)
    (hwCond[1] && !(isClr && wrData[1])) |=> flagQ[1]);

  assert_enable_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    isEn |=> (enQ == $past(wrData[NUM_SRC-1:0])));

  assert_irq_matches_status_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == ADDR_W'(3)) |-> (irq == (rdData != '0)));
endmodule

bind intflag_top intflag_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .wrAddr (wrAddr),
  .wrData (wrData),
  .rdAddr (rdAddr),
  .rdData (rdData),
  .hwCond (hwCond),
  .flagQ  (flagQ),
  .enQ    (enQ),
  .irq    (irq)
);

// File: tb/intflag_top_bench.sv
module intflag_top_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [1:0] rdAddr = '0;
  logic [7:0] rdData;
  logic [1:0] hwCond = '0;
  logic       irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  intflag_top u_intflag_top (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .hwCond(hwCond), .irq(irq)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk);
    #1;
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic regRead(input logic [1:0] a, output int v);
    rdAddr = a;
    #1;
    v = int'(rdData);
  endtask

  initial begin
    int v;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R9 reset state
    for (int a = 0; a < 4; a++) begin
      regRead(2'(a), v);
      check("R9 reset readback", v, 0);
    end
    check("R9 reset irq", int'(irq), 0);

    // R2 R6 R7 R8: every forced pattern against every enable pattern
    for (int s = 0; s < 4; s++) begin
      for (int e = 0; e < 4; e++) begin
        regWrite(2'd0, 8'hFF);
        regWrite(2'd2, 8'(e));
        regWrite(2'd1, 8'(s));
        regRead(2'd0, v); check("R2 forced flags", v, s);
        regRead(2'd3, v); check("R7 masked status", v, s & e);
        regRead(2'd2, v); check("R6 enable readback", v, e);
        check("R8 irq", int'(irq), int'((s & e) != 0));
      end
    end

    // R3: every clear mask against every flag pattern
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 4; c++) begin
        regWrite(2'd0, 8'hFF);
        regWrite(2'd1, 8'(s));
        regWrite(2'd0, 8'(c));
        regRead(2'd1, v); check("R3 clear mask", v, s & ~c & 3);
      end
    end

    // R1: high bits ignored and read zero
    regWrite(2'd0, 8'hFF);
    regWrite(2'd1, 8'hFC);
    regRead(2'd0, v); check("R1 set high bits ignored", v, 0);
    regWrite(2'd2, 8'hFF);
    regRead(2'd2, v); check("R1 enable high bits read zero", v, 3);
    regWrite(2'd1, 8'hFF);
    regRead(2'd3, v); check("R1 status width", v, 3);
    regWrite(2'd0, 8'hFF);

    // R4: receive condition sets flag, flag stays after it drops
    @(negedge clk); hwCond = 2'b10;
    @(posedge clk); #1;
    regRead(2'd0, v); check("R4 rx condition sets flag", v, 2);
    check("R4 irq from rx", int'(irq), 1);
    @(negedge clk); hwCond = 2'b00;
    @(posedge clk); #1;
    regRead(2'd0, v); check("R4 rx flag sticky", v, 2);
    regWrite(2'd0, 8'h02);
    regRead(2'd0, v); check("R4 rx flag cleared", v, 0);

    // R5: clear during live transmit condition
    @(negedge clk); hwCond = 2'b01;
    @(posedge clk); #1;
    regRead(2'd0, v); check("R5 tx condition sets flag", v, 1);
    regWrite(2'd0, 8'h01);
    regRead(2'd0, v); check("R5 low for one cycle", v, 0);
    check("R5 irq low in gap", int'(irq), 0);
    @(posedge clk); #1;
    regRead(2'd0, v); check("R5 flag set again", v, 1);
    @(negedge clk); hwCond = 2'b00;

    // R7 unmasked readback while masked off
    regWrite(2'd2, 8'h00);
    regRead(2'd1, v); check("R7 raw flags under mask", v, 1);
    regRead(2'd3, v); check("R7 status masked off", v, 0);
    check("R8 irq masked off", int'(irq), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule